// File: doc/BRIEF.md
# Extended-Data-Out Output Drive Controller

This block decides, once per clock, whether the 16-bit data outputs of an extended-data-out memory are driven and which word they carry. It watches the row strobe, the column strobe, the output enable and the write enable, all active low, as already-synchronous samples. A read starts on a sampled fall of the column strobe with write enable high. A fixed number of clocks later the word from the array is captured into an output register. That word stays on the pins after the column strobe rises again, which is what allows a short page cycle.

The drivers can be switched off in several ways. Output enable gates them directly. Two output-enable timing patterns during the strobe-high period, a held write enable, an early write and a fully idle pair of strobes each latch a sticky "off" state. Only the next read-type fall of the column strobe clears it. All three window lengths and the read latency are parameters counted in clock cycles.

Top module: `edo_oe_ctrl`

## Requirements
- R1: While reset is high and after its release with both strobes high, dq_oe is 0 and dq_out is 0.
- R2: A column-strobe fall sampled with we_n high makes dq_oe 0 after that edge. Exactly RD_LAT clocks after it, dq_out holds rd_data and dq_oe is 1 if oe_n is low and we_n is high.
- R3: After the column strobe rises with ras_n low, oe_n low and we_n high, dq_oe stays 1 and dq_out keeps the read word.
- R4: While the column strobe is low, raising oe_n turns dq_oe to 0 one clock later. Lowering it again brings dq_oe back to 1 with the same dq_out.
- R5: If oe_n is high at the column-strobe rise and stays high for HOLD_CYC samples, dq_oe remains 0 until the next read fall, whatever oe_n does. A shorter high run lets the outputs return.
- R6: If oe_n is low at the column-strobe rise and later goes high for PULSE_CYC consecutive samples while the strobe is high, dq_oe remains 0 until the next read fall.
- R7: An oe_n high run shorter than PULSE_CYC during the strobe-high period does not latch the off state.
- R8: Any sample with we_n low makes dq_oe 0 on the next clock. A low run of WPZ_CYC samples keeps dq_oe at 0 until a column-strobe fall with we_n high. A shorter run does not.
- R9: A sample with both ras_n and cas_n high makes dq_oe 0 on the next clock, and it stays 0 until the next read fall.
- R10: A row-strobe rise and fall while the column strobe stays low leaves dq_oe and dq_out unchanged. New data appears only after the column strobe has been pulsed high and falls again.
- R11: A column-strobe fall sampled with we_n low keeps dq_oe at 0 and leaves dq_out unchanged, even after we_n returns high.
- R12: dq_out changes only at the capture clock RD_LAT cycles after a read fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe (first-low of both byte strobes), active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_data | input | DW | Word delivered by the array for the current read |
| dq_out | output | DW | Registered output data word |
| dq_oe | output | 1 | Registered output-driver enable |

## Verification
The assertions take the strobes and enables to be clean, already-synchronous levels sampled once per clock. They also take rd_data to be steady from the read fall until the capture clock, RD_LAT to be at least one, and every window to be at least one cycle. The bench changes inputs only one nanosecond after a rising edge and sets rd_data before each column-strobe fall. It uses window lengths of two and three cycles, so that runs one sample short of each window can be told apart from runs that meet it.

// File: rtl/edo_oe_pkg.sv
package edo_oe_pkg;
  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/edo_oe_run.sv
module edo_oe_run #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  output logic [W-1:0] run_nx,
  output logic [W-1:0] run_q
);
  always_comb begin
    if (!cnt_en)           run_nx = '0;
    else if (run_q == '1)  run_nx = run_q;
    else                   run_nx = run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= run_nx;
  end
endmodule

// File: rtl/edo_oe_rd_latch.sv
module edo_oe_rd_latch #(
  parameter int unsigned DW     = 16,
  parameter int unsigned RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] dq_q,
  output logic          valid_nx
);
  localparam int unsigned CW = $clog2(RD_LAT + 1);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          valid_q, load;

  always_comb begin
    load = !start && (cnt_q == CW'(1));
    if (start)              cnt_nx = CW'(RD_LAT);
    else if (cnt_q != '0)   cnt_nx = cnt_q - 1'b1;
    else                    cnt_nx = '0;
    if (start)      valid_nx = 1'b0;
    else if (load)  valid_nx = 1'b1;
    else            valid_nx = valid_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
      dq_q    <= '0;
    end else begin
      cnt_q   <= cnt_nx;
      valid_q <= valid_nx;
      if (load) dq_q <= rd_data;
    end
  end

  AST_DATA_ONLY_AT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_q) != CW'(1)) |-> $stable(dq_q)); // R12
endmodule

// File: rtl/edo_oe_ctrl.sv
module edo_oe_ctrl
  import edo_oe_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned PULSE_CYC = 1,
  parameter int unsigned WPZ_CYC   = 1,
  parameter int unsigned RD_LAT    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  localparam int unsigned TMAX = max3(HOLD_CYC, PULSE_CYC, WPZ_CYC);
  localparam int unsigned RW   = $clog2(TMAX + 1) + 1;

  logic cas_q, fr_q, fr_nx, off_q, off_nx;
  logic cas_fall, cas_rise, rd_start, quiet;
  logic oe_hit, we_hit, valid_nx, drive_nx;
  logic [RW-1:0] oe_run_nx, oe_run_q, we_run_nx, we_run_q;
  logic [RW-1:0] oe_thr;

  assign cas_fall = cas_q && !cas_n;
  assign cas_rise = !cas_q && cas_n;
  assign rd_start = cas_fall && we_n;
  assign quiet    = ras_n && cas_n;

  edo_oe_run #(.W(RW)) u_oe_run (
    .clk(clk), .rst(rst), .cnt_en(cas_n && oe_n),
    .run_nx(oe_run_nx), .run_q(oe_run_q)
  );

  edo_oe_run #(.W(RW)) u_we_run (
    .clk(clk), .rst(rst), .cnt_en(!we_n),
    .run_nx(we_run_nx), .run_q(we_run_q)
  );

  edo_oe_rd_latch #(.DW(DW), .RD_LAT(RD_LAT)) u_rd (
    .clk(clk), .rst(rst), .start(rd_start), .rd_data(rd_data),
    .dq_q(dq_out), .valid_nx(valid_nx)
  );

  always_comb begin
    fr_nx    = cas_rise ? oe_n : (cas_n && oe_n && fr_q);
    oe_thr   = fr_nx ? RW'(HOLD_CYC) : RW'(PULSE_CYC);
    oe_hit   = cas_n && oe_n && (oe_run_nx >= oe_thr);
    we_hit   = !we_n && (we_run_nx >= RW'(WPZ_CYC));
    if (rd_start) off_nx = 1'b0;
    else          off_nx = off_q || oe_hit || we_hit || quiet || (cas_fall && !we_n);
    drive_nx = valid_nx && !off_nx && !oe_n && we_n && !quiet;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cas_q <= 1'b1;
      fr_q  <= 1'b0;
      off_q <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      cas_q <= cas_n;
      fr_q  <= fr_nx;
      off_q <= off_nx;
      dq_oe <= drive_nx;
    end
  end

  AST_IDLE_STROBES_OFF: assert property (@(posedge clk) disable iff (rst)
    (ras_n && cas_n) |=> !dq_oe); // R9
  AST_WRITE_EN_OFF: assert property (@(posedge clk) disable iff (rst)
    !we_n |=> !dq_oe); // R8
  AST_FRESH_READ_BLANK: assert property (@(posedge clk) disable iff (rst)
    (cas_q && !cas_n && we_n) |=> !dq_oe); // R2
  AST_STICKY_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (off_q && cas_n) |=> off_q); // R5
  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(!oe_n)); // R4
endmodule

// File: tb/edo_oe_ctrl_tb.sv
`timescale 1ns/1ps
module edo_oe_ctrl_tb;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst, ras_n, cas_n, oe_n, we_n;
  logic [DW-1:0] rd_data, dq_out;
  logic dq_oe;
  int   n_run = 0;
  int   n_fail = 0;
  logic [DW-1:0] last;

  always #2.5 clk = ~clk;

  edo_oe_ctrl #(.DW(DW), .HOLD_CYC(2), .PULSE_CYC(3), .WPZ_CYC(2), .RD_LAT(2)) u_dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n), .we_n(we_n),
    .rd_data(rd_data), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic eoe, input logic [DW-1:0] ed, input string tag);
    n_run++;
    if (dq_oe !== eoe || dq_out !== ed) begin
      n_fail++;
      $display("FAIL %s: dq_oe=%0b dq_out=%h expected dq_oe=%0b dq_out=%h",
               tag, dq_oe, dq_out, eoe, ed);
    end
  endtask

  // column strobe high, then a read fall; the word shows RD_LAT=2 clocks later
  task automatic read_word(input logic [DW-1:0] d);
    rd_data = d;
    cas_n = 1'b1; step();
    cas_n = 1'b0; step(); chk(1'b0, last, "R2 blank after fall");
    step();                chk(1'b0, last, "R12 no early capture");
    step();                chk(1'b1, d,    "R2 capture");
    last = d;
  endtask

  initial begin
    rst = 1'b1; ras_n = 1'b1; cas_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; rd_data = '0;
    last = '0;
    step(); step(); step();
    chk(1'b0, '0, "R1 in reset");
    rst = 1'b0; step();
    chk(1'b0, '0, "R1 after release");
    ras_n = 1'b0; step();
    chk(1'b0, '0, "R1 no read yet");

    // sweep of read words with page hold after the strobe rises
    for (int i = 0; i < 8; i++) begin
      logic [DW-1:0] v;
      v = 16'hA5C3 ^ (16'(i) * 16'h1357);
      read_word(v);
      cas_n = 1'b1; step(); chk(1'b1, v, "R3 hold after rise");
      step();               chk(1'b1, v, "R3 hold second clock");
    end

    // output enable toggling while the column strobe is low
    read_word(16'h1234);
    oe_n = 1'b1; step(); chk(1'b0, last, "R4 oe high");
    oe_n = 1'b0; step(); chk(1'b1, last, "R4 oe back low");

    // rise with oe high, run one short of HOLD_CYC
    oe_n = 1'b1; cas_n = 1'b1; step(); chk(1'b0, last, "R5 short hold off");
    oe_n = 1'b0; step();               chk(1'b1, last, "R5 short hold returns");

    // rise with oe high held for HOLD_CYC
    read_word(16'h2345);
    oe_n = 1'b1; cas_n = 1'b1; step(); chk(1'b0, last, "R5 hold run 1");
    step();                            chk(1'b0, last, "R5 hold run 2");
    oe_n = 1'b0; step();               chk(1'b0, last, "R5 sticky");
    step();                            chk(1'b0, last, "R5 sticky later");

    // rise with oe low, then pulses during strobe high
    read_word(16'h3456);
    cas_n = 1'b1; step(); chk(1'b1, last, "R3 rise oe low");
    oe_n = 1'b1; step(); step(); chk(1'b0, last, "R7 pulse in progress");
    oe_n = 1'b0; step();         chk(1'b1, last, "R7 short pulse returns");
    oe_n = 1'b1; step(); step(); step();
    oe_n = 1'b0; step();         chk(1'b0, last, "R6 pulse sticky");
    step();                      chk(1'b0, last, "R6 sticky later");

    // write enable pulses
    read_word(16'h4567);
    we_n = 1'b0; step(); chk(1'b0, last, "R8 we low off");
    we_n = 1'b1; step(); chk(1'b1, last, "R8 short we returns");
    we_n = 1'b0; step(); step(); chk(1'b0, last, "R8 long we off");
    we_n = 1'b1; step();         chk(1'b0, last, "R8 sticky after we");
    cas_n = 1'b1; step();        chk(1'b0, last, "R8 sticky strobe high");
    read_word(16'h5678);

    // early write: fall with we low
    we_n = 1'b0; cas_n = 1'b1; step(); chk(1'b0, last, "R11 we low before fall");
    cas_n = 1'b0; step(); step(); step(); chk(1'b0, last, "R11 early write off");
    we_n = 1'b1; step();                  chk(1'b0, last, "R11 stays off");
    read_word(16'h6789);

    // both strobes high
    ras_n = 1'b1; cas_n = 1'b1; step(); chk(1'b0, last, "R9 idle off");
    ras_n = 1'b0; step();               chk(1'b0, last, "R9 sticky after idle");
    read_word(16'h789A);

    // row strobe cycles while column strobe stays low
    rd_data = 16'hFFFF;
    ras_n = 1'b1; step(); chk(1'b1, last, "R10 ras high cas low");
    ras_n = 1'b0; step(); chk(1'b1, last, "R10 ras fall keeps data");
    step();               chk(1'b1, last, "R10 still previous");
    cas_n = 1'b1; step(); chk(1'b1, last, "R10 cas pulsed high");
    read_word(16'h89AB);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule